// File: doc/BRIEF.md
# Four-State Markov Burst Error Mask Generator

This block produces a burst error mask for a codeword under test. The mask is later XORed into a stored codeword to exercise an adjacent-error correcting decoder. The upsets follow a four-state chain: no upset, a one-bit upset, a two-bit upset, and an upset longer than two bits. A first pass marks upset starting points. Each bit in this pass is chosen on its own with a programmable probability. A second pass walks upward through the word. From each starting point it stretches a burst into the neighbouring bits, and the chance of growing again depends on how long the burst already is.

Every random decision compares a 16-bit threshold against a fresh draw from a 32-bit maximal-length LFSR. The LFSR is loaded from a seed when a run starts, so any mask can be reproduced from its seed, its thresholds and its width. A run is started by a single strobe. It takes one cycle per bit position in each pass. The finished mask is flagged by a one-cycle valid strobe and stays on the output until the next run starts.

Top module: `burst_mask_gen`

## Requirements
- R1: The LFSR is loaded with seed_i when a run starts, or with 1 when seed_i is zero. Each draw first advances it as s' = {s[30:0], s[31]^s[21]^s[1]^s[0]}, and the drawn value is s'[31:16]. A draw is a hit when that value is strictly below the threshold in use.
- R2: Seed pass: positions 0 up to W-1, where W is the effective width, each take exactly one draw in ascending order against thr_start_i. A position becomes a burst origin exactly when its draw hits. A threshold of 0 therefore gives an all-zero mask.
- R3: Growth pass: positions 0 up to W-1 are visited in ascending order, with a chain state that starts at none. At an origin no draw is made, the bit is set, and the state moves none→one, one→two, two→more or more→more. At a non-origin position with state none, no draw is made and the bit stays clear. At any other non-origin position one draw is made, against thr_grow1_i in state one, thr_grow2_i in state two and thr_growk_i in state more. A hit sets the bit and moves the state on; a miss clears the state to none.
- R4: Every burst origin is set in the final mask.
- R5: A burst ends at position W-1 and does not wrap, so no mask bit at or above W is ever set.
- R6: A run is accepted when start_i is high in a clock edge with busy_o low. busy_o is high from the next cycle through the cycle in which valid_o is high. valid_o is high for exactly one cycle, the one that follows the 2W-th edge after the accepting edge, and mask_o holds the finished mask in that cycle.
- R7: While a run is in progress, start_i is ignored, and changes to seed_i, width_i and the thresholds do not affect that run, because they are captured at the accepting edge.
- R8: A width_i of 0 is treated as W = 1, and a width_i above MAX_W is treated as W = MAX_W.
- R9: mask_o is cleared at the accepting edge and, once valid_o has been seen, holds its value until the next run is accepted.
- R10: During reset mask_o is all zero and valid_o and busy_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Run request, accepted when idle |
| seed_i | input | 32 | LFSR seed for the run |
| width_i | input | $clog2(MAX_W+1) | Codeword width in bits |
| thr_start_i | input | 16 | Origin probability threshold |
| thr_grow1_i | input | 16 | Growth threshold after one upset bit |
| thr_grow2_i | input | 16 | Growth threshold after two upset bits |
| thr_growk_i | input | 16 | Growth threshold after more than two upset bits |
| mask_o | output | MAX_W | Error mask, bit i for codeword bit i |
| valid_o | output | 1 | One-cycle strobe, mask complete |
| busy_o | output | 1 | Run in progress |

## Verification
The bench builds the block with MAX_W = 24. This keeps each run short, so many seeds and threshold sets fit in one run. It also lets growth thresholds near full scale drive bursts all the way into the top edge of the word. With a 5-bit width port, values above 24 and zero can both be applied, so both clamp directions of R8 can be reached. Runs with the small tuning values, with saturated origin and growth thresholds, and with a zero seed are each compared bit for bit against the behavioural chain model.

// File: rtl/burst_pkg.sv
package burst_pkg;
  typedef enum logic [1:0] {PH_IDLE, PH_SEED, PH_GROW, PH_DONE} phase_e;
  typedef enum logic [1:0] {CH_NONE, CH_ONE, CH_TWO, CH_MANY} chain_e;

  function automatic chain_e chain_adv(chain_e c);
    case (c)
      CH_NONE: chain_adv = CH_ONE;
      CH_ONE:  chain_adv = CH_TWO;
      default: chain_adv = CH_MANY;
    endcase
  endfunction
endpackage

// File: rtl/burst_lfsr.sv
module burst_lfsr #(
  parameter int unsigned LFSR_W = 32,
  parameter int unsigned RND_W  = 16,
  parameter logic [LFSR_W-1:0] TAPS = 32'h8020_0003
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [LFSR_W-1:0] seed_i,
  input  logic              step_i,
  output logic [RND_W-1:0]  rnd_o
);
  logic [LFSR_W-1:0] state_q, state_nxt;

  assign state_nxt = {state_q[LFSR_W-2:0], ^(state_q & TAPS)};
  // value used by the draw is taken from the advanced state
  assign rnd_o = state_nxt[LFSR_W-1 -: RND_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              state_q <= LFSR_W'(1);
    else if (load_i)          state_q <= (seed_i == '0) ? LFSR_W'(1) : seed_i;
    else if (step_i)          state_q <= state_nxt;
  end

  p_lfsr_nonzero_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q != '0)
    else $error("lfsr reached the all-zero lock state");
endmodule

// File: rtl/burst_prob_sel.sv
module burst_prob_sel
  import burst_pkg::*;
#(
  parameter int unsigned RND_W = 16
) (
  input  phase_e           phase_i,
  input  chain_e           chain_i,
  input  logic             origin_i,
  input  logic [RND_W-1:0] rnd_i,
  input  logic [RND_W-1:0] thr_start_i,
  input  logic [RND_W-1:0] thr_grow1_i,
  input  logic [RND_W-1:0] thr_grow2_i,
  input  logic [RND_W-1:0] thr_growk_i,
  output logic             draw_o,
  output logic             hit_o
);
  logic [RND_W-1:0] thr;

  always_comb begin
    draw_o = 1'b0;
    thr    = '0;
    case (phase_i)
      PH_SEED: begin
        draw_o = 1'b1;
        thr    = thr_start_i;
      end
      PH_GROW: begin
        draw_o = (chain_i != CH_NONE) && !origin_i;
        case (chain_i)
          CH_ONE:  thr = thr_grow1_i;
          CH_TWO:  thr = thr_grow2_i;
          CH_MANY: thr = thr_growk_i;
          default: thr = '0;
        endcase
      end
      default: ;
    endcase
  end

  assign hit_o = draw_o && (rnd_i < thr);
endmodule

// File: rtl/burst_seq.sv
module burst_seq
  import burst_pkg::*;
#(
  parameter int unsigned MAX_W = 80,
  localparam int unsigned WID_W = $clog2(MAX_W + 1),
  localparam int unsigned POS_W = $clog2(MAX_W)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [WID_W-1:0] width_i,
  output phase_e           phase_o,
  output logic [POS_W-1:0] pos_o,
  output logic [WID_W-1:0] eff_w_o,
  output logic             accept_o
);
  phase_e           phase_q;
  logic [POS_W-1:0] pos_q;
  logic [WID_W-1:0] eff_q, width_cl;
  logic             last;

  always_comb begin
    if (width_i == '0)                 width_cl = WID_W'(1);
    else if (width_i > WID_W'(MAX_W))  width_cl = WID_W'(MAX_W);
    else                               width_cl = width_i;
  end

  assign last     = (WID_W'(pos_q) + WID_W'(1)) == eff_q;
  assign accept_o = start_i && (phase_q == PH_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      pos_q   <= '0;
      eff_q   <= WID_W'(1);
    end else begin
      case (phase_q)
        PH_IDLE: if (start_i) begin
          phase_q <= PH_SEED;
          pos_q   <= '0;
          eff_q   <= width_cl;
        end
        PH_SEED: begin
          pos_q <= last ? '0 : pos_q + POS_W'(1);
          if (last) phase_q <= PH_GROW;
        end
        PH_GROW: begin
          pos_q <= last ? '0 : pos_q + POS_W'(1);
          if (last) phase_q <= PH_DONE;
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign phase_o = phase_q;
  assign pos_o   = pos_q;
  assign eff_w_o = eff_q;

  p_pos_range_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_SEED || phase_q == PH_GROW) |-> (WID_W'(pos_q) < eff_q))
    else $error("position beyond codeword width");

  p_run_advances_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((phase_q == PH_SEED || phase_q == PH_GROW) && !last)
      |=> (pos_q == POS_W'($past(pos_q) + POS_W'(1))))
    else $error("run disturbed while busy");

  p_done_one_cycle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_DONE) |=> (phase_q == PH_IDLE))
    else $error("done phase held");
endmodule

// File: rtl/burst_mask_gen.sv
module burst_mask_gen
  import burst_pkg::*;
#(
  parameter int unsigned MAX_W  = 80,
  parameter int unsigned LFSR_W = 32,
  parameter int unsigned RND_W  = 16,
  localparam int unsigned WID_W = $clog2(MAX_W + 1),
  localparam int unsigned POS_W = $clog2(MAX_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [LFSR_W-1:0] seed_i,
  input  logic [WID_W-1:0]  width_i,
  input  logic [RND_W-1:0]  thr_start_i,
  input  logic [RND_W-1:0]  thr_grow1_i,
  input  logic [RND_W-1:0]  thr_grow2_i,
  input  logic [RND_W-1:0]  thr_growk_i,
  output logic [MAX_W-1:0]  mask_o,
  output logic              valid_o,
  output logic              busy_o
);
  phase_e           phase;
  logic [POS_W-1:0] pos;
  logic [WID_W-1:0] eff_w;
  logic             accept, draw, hit, origin_here;
  logic [RND_W-1:0] rnd;
  logic [RND_W-1:0] ts_q, t1_q, t2_q, tk_q;
  logic [MAX_W-1:0] origin_q, mask_q, in_range;
  chain_e           chain_q;

  burst_seq #(.MAX_W(MAX_W)) u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .width_i  (width_i),
    .phase_o  (phase),
    .pos_o    (pos),
    .eff_w_o  (eff_w),
    .accept_o (accept)
  );

  burst_lfsr #(.LFSR_W(LFSR_W), .RND_W(RND_W)) u_lfsr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (accept),
    .seed_i (seed_i),
    .step_i (draw),
    .rnd_o  (rnd)
  );

  assign origin_here = origin_q[pos];

  burst_prob_sel #(.RND_W(RND_W)) u_sel (
    .phase_i     (phase),
    .chain_i     (chain_q),
    .origin_i    (origin_here),
    .rnd_i       (rnd),
    .thr_start_i (ts_q),
    .thr_grow1_i (t1_q),
    .thr_grow2_i (t2_q),
    .thr_growk_i (tk_q),
    .draw_o      (draw),
    .hit_o       (hit)
  );

  // thresholds captured per run
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ts_q <= '0; t1_q <= '0; t2_q <= '0; tk_q <= '0;
    end else if (accept) begin
      ts_q <= thr_start_i; t1_q <= thr_grow1_i;
      t2_q <= thr_grow2_i; tk_q <= thr_growk_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      origin_q <= '0;
      mask_q   <= '0;
      chain_q  <= CH_NONE;
    end else if (accept) begin
      origin_q <= '0;
      mask_q   <= '0;
      chain_q  <= CH_NONE;
    end else if (phase == PH_SEED) begin
      origin_q[pos] <= hit;
    end else if (phase == PH_GROW) begin
      if (origin_here) begin
        mask_q[pos] <= 1'b1;
        chain_q     <= chain_adv(chain_q);
      end else if (chain_q != CH_NONE) begin
        if (hit) begin
          mask_q[pos] <= 1'b1;
          chain_q     <= chain_adv(chain_q);
        end else begin
          chain_q <= CH_NONE;
        end
      end
    end
  end

  assign mask_o  = mask_q;
  assign valid_o = (phase == PH_DONE);
  assign busy_o  = (phase != PH_IDLE);

  for (genvar i = 0; i < MAX_W; i++) begin : g_range
    assign in_range[i] = (WID_W'(i) < eff_w);
  end

  p_no_overflow_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> ((mask_q & ~in_range) == '0))
    else $error("mask bit above codeword width");

  p_origin_kept_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> ((origin_q & ~mask_q) == '0))
    else $error("burst origin missing from mask");

  p_mask_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> $stable(mask_q))
    else $error("mask changed while idle");

  p_valid_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o)
    else $error("valid held longer than one cycle");
endmodule

// File: tb/burst_mask_gen_tb.sv
`timescale 1ns/1ps
module burst_mask_gen_tb;
  localparam int MW = 24;
  localparam int WW = $clog2(MW + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [31:0]   seed = '0;
  logic [WW-1:0] width = '0;
  logic [15:0]   ts = '0, t1 = '0, t2 = '0, tk = '0;
  logic [MW-1:0] mask;
  logic          valid, busy;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  burst_mask_gen #(.MAX_W(MW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .seed_i(seed),
    .width_i(width), .thr_start_i(ts), .thr_grow1_i(t1),
    .thr_grow2_i(t2), .thr_growk_i(tk),
    .mask_o(mask), .valid_o(valid), .busy_o(busy)
  );

  task automatic chk(input bit ok, input string req,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] adv(input logic [31:0] s);
    return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
  endfunction

  function automatic int eff_of(input int w);
    if (w == 0) return 1;
    if (w > MW) return MW;
    return w;
  endfunction

  // behavioural chain model
  function automatic logic [MW-1:0] model(input logic [31:0] sd, input int a,
      input int b, input int c, input int d, input int w);
    logic [31:0] s;
    bit org[MW];
    logic [MW-1:0] m;
    int st, thr;
    s = (sd == 0) ? 32'd1 : sd;
    m = '0;
    for (int p = 0; p < w; p++) begin
      s = adv(s);
      org[p] = (int'(s[31:16]) < a);
    end
    st = 0;
    for (int p = 0; p < w; p++) begin
      if (org[p]) begin
        m[p] = 1'b1;
        st = (st == 3) ? 3 : st + 1;
      end else if (st != 0) begin
        thr = (st == 1) ? b : (st == 2) ? c : d;
        s = adv(s);
        if (int'(s[31:16]) < thr) begin
          m[p] = 1'b1;
          st = (st == 3) ? 3 : st + 1;
        end else st = 0;
      end
    end
    return m;
  endfunction

  task automatic run(input string tag, input logic [31:0] sd, input int a,
      input int b, input int c, input int d, input int w, input bit poke);
    logic [MW-1:0] exp;
    int ew;
    ew  = eff_of(w);
    exp = model(sd, a, b, c, d, ew);
    @(negedge clk);
    seed = sd; width = WW'(w);
    ts = 16'(a); t1 = 16'(b); t2 = 16'(c); tk = 16'(d);
    start = 1'b1;
    for (int j = 0; j <= 2 * ew + 1; j++) begin
      @(negedge clk);
      start = 1'b0;
      if (poke && j == 1) begin
        // R7: disturb every input while busy
        start = 1'b1; seed = ~sd; width = WW'(1);
        ts = 16'hffff; t1 = 16'hffff; t2 = 16'hffff; tk = 16'hffff;
      end
      chk(valid == (j == 2 * ew), {tag, " R6 valid timing"}, 64'(valid), 64'(j == 2 * ew));
      chk(busy == (j <= 2 * ew), {tag, " R6 busy span"}, 64'(busy), 64'(j <= 2 * ew));
      if (j == 0)
        chk(mask == '0, {tag, " R9 cleared at accept"}, 64'(mask), 64'd0);
      if (j == 2 * ew)
        chk(mask == exp, {tag, " R1 R2 R3 R4 R5 mask"}, 64'(mask), 64'(exp));
    end
    start = 1'b0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(mask == exp, {tag, " R9 hold while idle"}, 64'(mask), 64'(exp));
    end
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(mask == '0, "R10 mask in reset", 64'(mask), 64'd0);
    chk(!valid && !busy, "R10 strobes in reset", 64'({valid, busy}), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!valid && !busy, "R10 idle after reset", 64'({valid, busy}), 64'd0);

    // R2 threshold zero never hits
    run("zero_origin", 32'h1234_5678, 0, 16'hffff, 16'hffff, 16'hffff, 24, 0);
    // R4 saturated origins
    run("all_origin", 32'hcafe_f00d, 16'hffff, 0, 0, 0, 24, 0);
    // R3 tuning-like values
    run("tuned_a", 32'h0bad_5eed, 16'h2000, 16'h0937, 16'h2666, 16'h9999, 24, 0);
    run("tuned_b", 32'h7777_1111, 16'h3000, 16'h0937, 16'h2666, 16'h9999, 16, 0);
    run("tuned_c", 32'h0000_9abc, 16'h4000, 16'h0937, 16'h2666, 16'h9999, 24, 0);
    // R3 R5 long bursts into top edge
    run("long_a", 32'h1357_9bdf, 16'h0c00, 16'hf000, 16'hf000, 16'hf800, 24, 0);
    run("long_b", 32'h2468_ace0, 16'h1800, 16'he000, 16'hc000, 16'hfff0, 24, 0);
    run("grow_split", 32'h5555_aaaa, 16'h1000, 16'hffff, 16'h0000, 16'hffff, 24, 0);
    // R1 zero seed substitution
    run("zero_seed", 32'h0, 16'h6000, 16'h8000, 16'h8000, 16'h8000, 20, 0);
    // R8 width clamps
    run("width_zero", 32'h0f0f_0f0f, 16'hffff, 16'hffff, 16'hffff, 16'hffff, 0, 0);
    run("width_over", 32'h3c3c_3c3c, 16'h2000, 16'hc000, 16'hc000, 16'hc000, 30, 0);
    run("width_one", 32'h8000_0001, 16'h9000, 16'hffff, 16'hffff, 16'hffff, 1, 0);
    run("width_odd", 32'hdead_beef, 16'h5000, 16'h9000, 16'h9000, 16'h9000, 7, 0);
    // R7 inputs changed mid-run
    run("busy_poke", 32'h1111_2222, 16'h3000, 16'h8000, 16'h6000, 16'h9999, 24, 1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule